// File: doc/BRIEF.md
# Programmable Double-Base Term Multiplier

This block forms the product of one input sample and one programmable coefficient magnitude for a single tap of a transposed-form FIR filter whose coefficients can change at run time. It has no general multiplier. The coefficient is held as at most three terms. Each term is a power of two times one of the odd constants 1, 3, 5, 9 or 27. One shared generator makes the odd multiples of the sample. Each term slot picks one candidate through a four-way selector and scales it with a programmable left shifter. The three terms are added, and a common left shift supplies the extra power of two that even coefficients need.

The control word for the current coefficient arrives on a plain input and is registered together with the product when the load strobe is high. The coefficient sign does not change the product. It is registered beside the product so that the tap's structural adder can subtract instead of add. Producing the control words is not part of this block.

Top module: `dbm_term_mult`

## Requirements
- R1: While `rst_ni` is low, `prod_o` and `sign_o` are 0, and they clear as soon as reset goes low, without waiting for a clock edge.
- R2: A rising clock edge with `load_i` high captures the product of the present `sample_i` and `ctrl_i`, and it appears on `prod_o` after that edge. At an edge with `load_i` low, `prod_o` and `sign_o` hold their values.
- R3: The layout of the control word, from LSB, is as follows. Slot k has its 2-bit select at bits [5k+1:5k] and its 3-bit shift at bits [5k+4:5k+2], for k = 0, 1, 2. The common shift sits at bits [17:15] and the sign at bit 18.
- R4: The select codes are: 0 gives zero, 1 gives the sample, and 2 and 3 give the slot's two extra multiples. These are 3x and 5x for slot 0, 9x and 27x for slot 1, and 3x and 9x for slot 2.
- R5: Each slot's term equals its selected multiple shifted left by the slot shift, from 0 to 7.
- R6: `prod_o` is the sum of the three terms shifted left by the common shift. It is a two's-complement value SW+8 bits wide, and a zero sample gives zero.
- R7: `sign_o` is the registered sign bit of the control word and has no effect on `prod_o`.
- R8: For every magnitude from 1 to 255 that has an encoding, the encoded product equals sample × magnitude. This includes even magnitudes, encoded as their odd part plus a common shift equal to the count of trailing zeros. 147 needs only two terms (9·16 + 3).
- R9: A control word whose three selects are all 0 gives a product of 0 for any shift values.
- R10: Full-scale samples (-32768 and 32767 at the default width) times magnitude 255 give the exact product, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture strobe for the product and sign |
| sample_i | input | SW | Signed input sample |
| ctrl_i | input | 19 | Coefficient control word (layout in R3) |
| prod_o | output | SW+8 | Registered signed magnitude product |
| sign_o | output | 1 | Registered coefficient sign |

## Verification
The bench searches every slot combination to find an encoding for each nonzero magnitude, then checks that all of them give the exact product for both full-scale samples and for small positive and negative samples. A slot wired to the wrong multiple, or a shifter stage with a misordered amount bit, shows up as a wrong product on many magnitudes. A missing common shift makes every even coefficient wrong. A sign extension that fails when the multiples are built wraps the negative full-scale result. Directed tests cover the following:
- Load/hold: a register enabled on the wrong condition changes `prod_o` while `load_i` is low.
- Zero coefficient: large shift values on unused slots would leak into a zero-coefficient product.
- Sign: a product negated by mistake in the sign path gives the wrong result.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

  localparam int unsigned MAG_W   = 8;
  localparam int unsigned N_SLOTS = 3;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned SH_W    = 3;
  localparam int unsigned CS_W    = 3;
  localparam int unsigned SLOT_W  = SEL_W + SH_W;
  localparam int unsigned CTRL_W  = N_SLOTS * SLOT_W + CS_W + 1;
  localparam int unsigned N_MULT  = 5;
  localparam int unsigned N_CAND  = 3;

  typedef enum logic [2:0] {
    MULT_X1  = 3'd0,
    MULT_X3  = 3'd1,
    MULT_X9  = 3'd2,
    MULT_X27 = 3'd3,
    MULT_X5  = 3'd4
  } mult_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_ZERO = 2'd0,
    SEL_X    = 2'd1,
    SEL_LO   = 2'd2,
    SEL_HI   = 2'd3
  } sel_e;

  typedef struct packed {
    logic [SH_W-1:0] shift;
    sel_e            sel;
  } slot_ctrl_t;

  typedef struct packed {
    logic                          sign;
    logic [CS_W-1:0]               cshift;
    slot_ctrl_t [N_SLOTS-1:0]      slot;
  } ctrl_t;

  // extra multiples wired to each slot; no slot sees all of them
  function automatic mult_e slot_extra(int unsigned slot, bit upper);
    mult_e r;
    case (slot)
      0:       r = upper ? MULT_X5  : MULT_X3;
      1:       r = upper ? MULT_X27 : MULT_X9;
      default: r = upper ? MULT_X9  : MULT_X3;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dbm_lshift.sv
module dbm_lshift #(
  parameter int unsigned W   = 24,
  parameter int unsigned SHW = 3
) (
  input  logic [W-1:0]   data_i,
  input  logic [SHW-1:0] amt_i,
  output logic [W-1:0]   data_o
);

  logic [SHW:0][W-1:0] stg;

  assign stg[0] = data_i;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    assign stg[s+1] = amt_i[s] ? (stg[s] << (1 << s)) : stg[s];
  end

  assign data_o = stg[SHW];

endmodule

// File: rtl/dbm_base_gen.sv
module dbm_base_gen
  import dbm_pkg::*;
#(
  parameter int unsigned SW        = 16,
  parameter int unsigned PW        = SW + MAG_W,
  parameter bit          LOW_DEPTH = 1'b1
) (
  input  logic [SW-1:0]             x_i,
  output logic [N_MULT-1:0][PW-1:0] mult_o
);

  logic [PW-1:0] x1, x3, x5, x9, x27;

  assign x1 = {{(PW-SW){x_i[SW-1]}}, x_i};
  assign x3 = x1 + (x1 << 1);
  assign x5 = x1 + (x1 << 2);

  if (LOW_DEPTH) begin : g_flat
    // 9x beside 3x, 27x from 3x: two adder levels
    assign x9  = x1 + (x1 << 3);
    assign x27 = x3 + (x3 << 3);
  end else begin : g_chain
    assign x9  = x3 + (x3 << 1);
    assign x27 = x9 + (x9 << 1);
  end

  always_comb begin
    mult_o           = '0;
    mult_o[MULT_X1]  = x1;
    mult_o[MULT_X3]  = x3;
    mult_o[MULT_X9]  = x9;
    mult_o[MULT_X27] = x27;
    mult_o[MULT_X5]  = x5;
  end

endmodule

// File: rtl/dbm_term_slot.sv
module dbm_term_slot
  import dbm_pkg::*;
#(
  parameter int unsigned PW = 24
) (
  input  logic [N_CAND-1:0][PW-1:0] cand_i,  // {hi, lo, x}
  input  slot_ctrl_t                ctrl_i,
  output logic [PW-1:0]             term_o
);

  logic [PW-1:0] pick;

  always_comb begin
    case (ctrl_i.sel)
      SEL_X:   pick = cand_i[0];
      SEL_LO:  pick = cand_i[1];
      SEL_HI:  pick = cand_i[2];
      default: pick = '0;
    endcase
  end

  dbm_lshift #(.W(PW), .SHW(SH_W)) u_shift (
    .data_i (pick),
    .amt_i  (ctrl_i.shift),
    .data_o (term_o)
  );

endmodule

// File: rtl/dbm_term_sum.sv
module dbm_term_sum
  import dbm_pkg::*;
#(
  parameter int unsigned PW = 24,
  parameter int unsigned N  = N_SLOTS
) (
  input  logic [N-1:0][PW-1:0] term_i,
  input  logic [CS_W-1:0]      cshift_i,
  output logic [PW-1:0]        sum_o
);

  logic [PW-1:0] acc;

  // wraps mod 2^PW; a valid encoding lands inside the range
  always_comb begin
    acc = '0;
    for (int k = 0; k < N; k++) acc = acc + term_i[k];
  end

  dbm_lshift #(.W(PW), .SHW(CS_W)) u_cshift (
    .data_i (acc),
    .amt_i  (cshift_i),
    .data_o (sum_o)
  );

endmodule

// File: rtl/dbm_term_mult.sv
module dbm_term_mult
  import dbm_pkg::*;
#(
  parameter int unsigned SW = 16,
  parameter bit LOW_DEPTH   = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [SW-1:0]        sample_i,
  input  logic [CTRL_W-1:0]    ctrl_i,
  output logic [SW+MAG_W-1:0]  prod_o,
  output logic                 sign_o
);

  localparam int unsigned PW = SW + MAG_W;

  ctrl_t                      ctrl;
  logic [N_MULT-1:0][PW-1:0]  mult;
  logic [N_SLOTS-1:0][PW-1:0] term;
  logic [PW-1:0]              prod_d, prod_q;
  logic                       sign_q;

  assign ctrl = ctrl_t'(ctrl_i);

  dbm_base_gen #(.SW(SW), .PW(PW), .LOW_DEPTH(LOW_DEPTH)) u_base (
    .x_i    (sample_i),
    .mult_o (mult)
  );

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    localparam mult_e LO = slot_extra(g, 1'b0);
    localparam mult_e HI = slot_extra(g, 1'b1);
    logic [N_CAND-1:0][PW-1:0] cand;
    assign cand = {mult[HI], mult[LO], mult[MULT_X1]};
    dbm_term_slot #(.PW(PW)) u_slot (
      .cand_i (cand),
      .ctrl_i (ctrl.slot[g]),
      .term_o (term[g])
    );
  end

  dbm_term_sum #(.PW(PW), .N(N_SLOTS)) u_sum (
    .term_i   (term),
    .cshift_i (ctrl.cshift),
    .sum_o    (prod_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      sign_q <= 1'b0;
    end else if (load_i) begin
      prod_q <= prod_d;
      sign_q <= ctrl.sign;
    end
  end

  assign prod_o = prod_q;
  assign sign_o = sign_q;

endmodule

// File: rtl/dbm_term_mult_chk.sv
module dbm_term_mult_chk
  import dbm_pkg::*;
#(
  parameter int unsigned SW = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                load_i,
  input logic [SW-1:0]       sample_i,
  input logic [CTRL_W-1:0]   ctrl_i,
  input logic [SW+MAG_W-1:0] prod_o,
  input logic                sign_o
);

  localparam int unsigned PW = SW + MAG_W;

  ctrl_t         c;
  logic [PW-1:0] sx;
  logic          all_zero;

  assign c        = ctrl_t'(ctrl_i);
  assign sx       = {{(PW-SW){sample_i[SW-1]}}, sample_i};
  assign all_zero = (c.slot[0].sel == SEL_ZERO) && (c.slot[1].sel == SEL_ZERO) &&
                    (c.slot[2].sel == SEL_ZERO);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(prod_o) && $stable(sign_o)));

  assert_sign_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sign_o == $past(c.sign)));

  assert_zero_coef_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && all_zero) |=> (prod_o == '0));

  assert_zero_sample_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && sample_i == '0) |=> (prod_o == '0));

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_single
    logic only_g;
    always_comb begin
      only_g = (c.slot[g].sel == SEL_X) && (c.cshift == '0);
      for (int k = 0; k < N_SLOTS; k++)
        if (k != g && c.slot[k].sel != SEL_ZERO) only_g = 1'b0;
    end
    // lone sample term: product is the shifted sample
    assert_single_term_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && only_g) |=> (prod_o == ($past(sx) << $past(c.slot[g].shift))));
  end

endmodule

bind dbm_term_mult dbm_term_mult_chk #(.SW(SW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .sample_i (sample_i),
  .ctrl_i   (ctrl_i),
  .prod_o   (prod_o),
  .sign_o   (sign_o)
);

// File: tb/dbm_term_mult_bench.sv
`timescale 1ns/1ps
module dbm_term_mult_bench;

  localparam int SW   = 16;
  localparam int PW   = SW + 8;
  localparam int CW   = 19;
  localparam int NVEC = 9;

  // sample, sel0, sh0, sel1, sh1, sel2, sh2, cshift, sign, expected
  localparam int VEC [NVEC][10] = '{
    '{   100, 1, 0, 0, 0, 0, 0, 0, 0,      100},
    '{     7, 2, 0, 2, 4, 0, 0, 0, 0,     1029},
    '{    -3, 2, 0, 3, 3, 3, 2, 0, 1,     -765},
    '{  -100, 1, 6, 0, 0, 3, 0, 1, 1,   -14600},
    '{ 12345, 0, 7, 0, 7, 0, 7, 7, 0,        0},
    '{-32768, 2, 0, 3, 3, 3, 2, 0, 0, -8355840},
    '{ 32767, 2, 0, 3, 3, 3, 2, 0, 1,  8355585},
    '{     9, 3, 1, 1, 0, 0, 0, 2, 0,      396},
    '{     2, 0, 0, 0, 0, 2, 7, 0, 0,      768}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic [SW-1:0] sample_i = '0;
  logic [CW-1:0] ctrl_i = '0;
  logic [PW-1:0] prod_o;
  logic          sign_o;

  int n_chk  = 0;
  int n_fail = 0;

  logic [CW-1:0] enc_word [256];
  bit            enc_ok   [256];

  always #10 clk_i = ~clk_i;

  dbm_term_mult u_dbm_term_mult (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .sample_i (sample_i),
    .ctrl_i   (ctrl_i),
    .prod_o   (prod_o),
    .sign_o   (sign_o)
  );

  function automatic logic [CW-1:0] mk_ctrl(int s0, int h0, int s1, int h1,
                                            int s2, int h2, int cs, int sg);
    return {sg[0], cs[2:0], h2[2:0], s2[1:0], h1[2:0], s1[1:0], h0[2:0], s0[1:0]};
  endfunction

  // R4: value selected by a code in a given slot
  function automatic int base_of(int slot, int sel);
    case (sel)
      0: return 0;
      1: return 1;
      2: return (slot == 1) ? 9 : 3;
      default: return (slot == 0) ? 5 : ((slot == 1) ? 27 : 9);
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(logic [SW-1:0] s, logic [CW-1:0] c);
    @(negedge clk_i);
    sample_i = s;
    ctrl_i   = c;
    load_i   = 1'b1;
    @(negedge clk_i);
    load_i   = 1'b0;
  endtask

  task automatic build_table();
    for (int m = 0; m < 256; m++) enc_ok[m] = 1'b0;
    for (int a0 = 0; a0 < 4; a0++)
      for (int b0 = 0; b0 < 8; b0++)
        for (int a1 = 0; a1 < 4; a1++)
          for (int b1 = 0; b1 < 8; b1++)
            for (int a2 = 0; a2 < 4; a2++)
              for (int b2 = 0; b2 < 8; b2++) begin
                int v;
                v = (base_of(0, a0) << b0) + (base_of(1, a1) << b1) + (base_of(2, a2) << b2);
                if (v > 0 && v < 256 && v[0] && !enc_ok[v]) begin
                  enc_ok[v]   = 1'b1;
                  enc_word[v] = mk_ctrl(a0, b0, a1, b1, a2, b2, 0, 0);
                end
              end
    // R8: even magnitude = odd part plus common shift
    for (int m = 2; m < 256; m += 2) begin
      int o, tz;
      o = m; tz = 0;
      while (!o[0]) begin o = o >> 1; tz++; end
      if (enc_ok[o]) begin
        enc_ok[m]   = 1'b1;
        enc_word[m] = enc_word[o];
        enc_word[m][17:15] = tz[2:0];
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int samples [4];
    int missing;
    samples = '{-32768, 32767, 1234, -77};
    missing = 0;

    // R1: reset state
    repeat (2) @(negedge clk_i);
    check("R1 prod in reset", int'($signed(prod_o)), 0);
    check("R1 sign in reset", int'(sign_o), 0);
    rst_ni = 1'b1;

    // R3 R4 R5 R6 R7 R9 R10: table walk
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][0][SW-1:0],
            mk_ctrl(VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4],
                    VEC[i][5], VEC[i][6], VEC[i][7], VEC[i][8]));
      check($sformatf("R3 R4 R6 vector %0d product", i), int'($signed(prod_o)), VEC[i][9]);
      check($sformatf("R7 vector %0d sign", i), int'(sign_o), VEC[i][8]);
    end

    // R2: hold while load low, then latency of one edge
    apply(16'sd7, mk_ctrl(2, 0, 2, 4, 0, 0, 0, 1));
    @(negedge clk_i);
    sample_i = 16'sd999;
    ctrl_i   = mk_ctrl(1, 3, 3, 2, 2, 1, 2, 0);
    repeat (3) @(negedge clk_i);
    check("R2 hold product", int'($signed(prod_o)), 1029);
    check("R2 hold sign", int'(sign_o), 1);
    sample_i = 16'sd5;
    ctrl_i   = mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0);
    load_i   = 1'b1;
    #1;
    check("R2 no change before edge", int'($signed(prod_o)), 1029);
    @(negedge clk_i);
    load_i = 1'b0;
    check("R2 product after edge", int'($signed(prod_o)), 5);

    // R9: zero coefficient with nonzero shifts on a negative sample
    apply(-16'sd1, mk_ctrl(0, 5, 0, 6, 0, 3, 4, 1));
    check("R9 zero coefficient", int'($signed(prod_o)), 0);

    // R8 R10: all magnitudes with searched encodings
    build_table();
    for (int si = 0; si < 4; si++) begin
      for (int m = 1; m < 256; m++) begin
        if (enc_ok[m]) begin
          logic [CW-1:0] w;
          w = enc_word[m];
          w[18] = m[0];
          apply(samples[si][SW-1:0], w);
          check($sformatf("R8 R10 sample %0d mag %0d", samples[si], m),
                int'($signed(prod_o)), samples[si] * m);
          check($sformatf("R7 sign mag %0d", m), int'(sign_o), m & 1);
        end else if (si == 0) begin
          missing++;
        end
      end
    end
    if (missing != 0) $display("note: %0d magnitudes have no encoding", missing);

    // R1: asynchronous clear mid-run
    apply(16'sd300, mk_ctrl(1, 2, 0, 0, 0, 0, 0, 1));
    check("R1 loaded before reset", int'($signed(prod_o)), 1200);
    #3;
    rst_ni = 1'b0;
    #1;
    check("R1 async clear product", int'($signed(prod_o)), 0);
    check("R1 async clear sign", int'(sign_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule